// File: doc/BRIEF.md
# Presettable Decade Counter with Asynchronous Clear

This block is a single-digit synchronous decade counter that advances on the rising clock edge. A synchronous parallel preset, active low, copies a four-bit data word into the counter on every rising edge while it is asserted. The counter therefore sits on the preset value until the preset is released, and the first edge after release increments it. With the preset released, the counter steps through the BCD codes 0 to 9 and wraps to 0. An active-low clear forces the count to zero at once, without waiting for a clock edge, and overrides both preset and counting.

Codes 10 to 15 can be preset. From such a code the counter keeps adding one on each edge, and code 15 rolls to 0, so it is back in the decimal range within six edges. A combinational carry output flags the last count of a decade so that a following digit can be enabled from it. No data stream crosses this block: every clock edge is one count step and every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `decade_preset_counter`

## Requirements
- R1: While `clr_n` is low, `count_q` is 0000 within the same time step, with no clock edge required.
- R2: Clear overrides preset and counting: rising edges seen while `clr_n` is low leave `count_q` at 0000, whatever `load_n` and `preset_d` are.
- R3: With `clr_n` high and `load_n` low at a rising edge, `count_q` takes the value of `preset_d` after that edge. All 16 codes are accepted.
- R4: While `load_n` stays low and `preset_d` is unchanged, further edges leave `count_q` unchanged.
- R5: With `load_n` high and `count_q` in 0 to 8, each rising edge increments `count_q` by one.
- R6: With `load_n` high and `count_q` equal to 9, the next rising edge sets `count_q` to 0.
- R7: With `load_n` high, codes 10 to 14 step to the next code and code 15 steps to 0, so any preset code is back in 0 to 9 within six edges.
- R8: `carry_o` is high exactly when `count_q` is 9 and `load_n` is high. It is combinational in both inputs and is followed by a zero count on the next edge.
- R9: The first rising edge after `load_n` returns high increments the held preset by one, following R5 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low, holds while low |
| preset_d | input | 4 | Preset data word (bit 0 is the least significant) |
| count_q | output | 4 | Current count, binary-coded |
| carry_o | output | 1 | High on count 9 while counting (terminal count) |

## Verification
The state of this block is exactly the visible count, so a wrong next-state value appears on `count_q` at the very edge that produces it. A wrong recovery path from codes 10 to 15 shows up within at most six edges as a count that never returns to 0 to 9 or that skips a code. A clear that depends on the clock shows as a nonzero count in the same time step that `clr_n` falls. A carry decoded on the wrong code or ignoring the preset shows immediately, because it is compared with the count on every cycle.

// File: rtl/decade_cnt_pkg.sv
package decade_cnt_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned LAST_DEC = 9;
  localparam int unsigned LAST_CODE = (1 << DIGIT_W) - 1;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Count step while the preset is released: decimal wrap at the last
  // decimal code, binary roll-over above it.
  function automatic digit_t step_code(input digit_t cur);
    if (cur == digit_t'(LAST_DEC) || cur == digit_t'(LAST_CODE))
      return '0;
    return cur + digit_t'(1);
  endfunction
endpackage

// File: rtl/decade_cnt_next.sv
module decade_cnt_next
  import decade_cnt_pkg::*;
(
  input  logic   load_n,
  input  digit_t preset_d,
  input  digit_t cur_q,
  output digit_t nxt_d
);
  always_comb begin
    if (!load_n) nxt_d = preset_d;
    else         nxt_d = step_code(cur_q);
  end
endmodule

// File: rtl/decade_cnt_reg.sv
module decade_cnt_reg
  import decade_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   clr_n,
  input  digit_t nxt_d,
  output digit_t cur_q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) cur_q <= '0;
    else        cur_q <= nxt_d;
  end
endmodule

// File: rtl/decade_cnt_carry.sv
module decade_cnt_carry
  import decade_cnt_pkg::*;
(
  input  digit_t cur_q,
  input  logic   load_n,
  output logic   carry_o
);
  assign carry_o = load_n && (cur_q == digit_t'(LAST_DEC));
endmodule

// File: rtl/decade_preset_counter.sv
module decade_preset_counter
  import decade_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic [3:0] preset_d,
  output logic [3:0] count_q,
  output logic       carry_o
);
  digit_t nxt;

  decade_cnt_next u_next (
    .load_n  (load_n),
    .preset_d(preset_d),
    .cur_q   (count_q),
    .nxt_d   (nxt)
  );

  decade_cnt_reg u_reg (
    .clk  (clk),
    .clr_n(clr_n),
    .nxt_d(nxt),
    .cur_q(count_q)
  );

  decade_cnt_carry u_carry (
    .cur_q  (count_q),
    .load_n (load_n),
    .carry_o(carry_o)
  );

  AST_CLR_ZERO: assert property (@(posedge clk) !clr_n |-> count_q == '0); // R2
  AST_PRESET_COPY: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count_q == $past(preset_d)); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && count_q < 4'd9) |=> count_q == $past(count_q) + 4'd1); // R5
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && count_q == 4'd9) |=> count_q == '0); // R6
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && count_q >= 4'd10 && count_q <= 4'd14) |=> count_q == $past(count_q) + 4'd1); // R7
  AST_OVR_ROLL: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && count_q == 4'd15) |=> count_q == '0); // R7
  AST_CARRY_NEXT_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    carry_o |=> count_q == '0); // R8
endmodule

// File: tb/test_decade_preset_counter.sv
`timescale 1ns/1ps
module test_decade_preset_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset_d = 4'd0;
  logic [3:0] count_q;
  logic       carry_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  decade_preset_counter i_decade_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n),
    .preset_d(preset_d), .count_q(count_q), .carry_o(carry_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, then settle 1 ns before checking or driving
  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  function automatic int model_step(input int v);
    return (v == 9 || v == 15) ? 0 : v + 1;
  endfunction

  initial begin
    int exp;
    #1;
    chk("R1 reset", count_q, 0);
    edge1();
    chk("R2 clear holds", count_q, 0);
    clr_n = 1'b1;
    // sweep every preset code
    for (int p = 0; p < 16; p++) begin
      load_n = 1'b0;
      preset_d = 4'(p);
      #0.1;
      chk("R8 carry low under preset", carry_o, 0);
      edge1();
      chk("R3 preset copy", count_q, p);
      edge1();
      edge1();
      chk("R4 preset hold", count_q, p);
      chk("R8 carry low under preset", carry_o, 0);
      load_n = 1'b1;
      #0.1;
      chk("R8 carry level", carry_o, (p == 9) ? 1 : 0);
      exp = p;
      for (int k = 0; k < 22; k++) begin
        edge1();
        exp = model_step(exp);
        if (k == 0) chk("R9 first step after preset", count_q, exp);
        else if (exp == 0 && (k == 0 || 1)) chk("R6/R7 wrap", count_q, exp);
        else chk("R5 step", count_q, exp);
        chk("R8 carry", carry_o, (exp == 9) ? 1 : 0);
        if (p >= 10 && k == 5) chk("R7 recovered", (count_q <= 9) ? 1 : 0, 1);
      end
    end
    // asynchronous clear between edges, mid count
    load_n = 1'b0; preset_d = 4'd7;
    edge1();
    load_n = 1'b1;
    edge1();
    chk("R5 step from 7", count_q, 8);
    #0.5;
    clr_n = 1'b0;
    #0.2;
    chk("R1 async clear", count_q, 0);
    load_n = 1'b0; preset_d = 4'd5;
    edge1();
    chk("R2 clear beats preset", count_q, 0);
    load_n = 1'b1;
    edge1();
    chk("R2 clear beats count", count_q, 0);
    clr_n = 1'b1;
    edge1();
    chk("R5 count after clear", count_q, 1);
    // carry drops with preset even at count 9
    load_n = 1'b0; preset_d = 4'd9;
    edge1();
    chk("R8 carry masked by preset", carry_o, 0);
    load_n = 1'b1;
    #0.1;
    chk("R8 carry on 9", carry_o, 1);
    edge1();
    chk("R6 wrap 9 to 0", count_q, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule